// File: doc/BRIEF.md
# RTC Periodic Interrupt and Event Flag Unit

This block turns elapsed time into a periodic interrupt for a real-time clock and keeps the interrupt source flags that software reads back. A free-running microsecond timebase reports elapsed time as a strobe plus a step count. The block adds each step into an accumulator and compares the total against a period. That period comes from a 4-bit rate code: the code shifts a 65536 Hz base frequency down, and the resulting period is 1,000,000 divided by that frequency, in whole microseconds. When the accumulator reaches the period, the block subtracts the period and keeps what is left over, so the average rate does not drift.

The time counter next to this block supplies single-cycle update and alarm pulses. A control byte carries one enable bit per source. Each event sets its own flag only when its enable bit is set. The block presents the flags as a status byte, whose top bit is the OR of the three flags, and it drives a level-sensitive interrupt request from that summary bit. A read strobe returns the byte as it stands and clears every flag, which drops the request. No part of the block carries a data stream: every pin is a plain control or status signal with no handshake and no back-pressure.

Top module: `rtc_event_irq`

## Requirements
- R1: The rate code is `rate_sel[3:0]`. For a code c from 1 to 15, the period is P = 1000000 / (65536 >> c) in integer microseconds (c=6 gives 976). A periodic event occurs on a cycle with `us_tick` high when accumulator + `us_step` >= P.
- R2: On a periodic event, P is subtracted from accumulator + `us_step` and the remainder is kept. Otherwise the accumulator becomes accumulator + `us_step`.
- R3: A rate code of 0 produces no periodic events and clears the accumulator on every cycle it is applied.
- R4: A flag is set only when its event occurs and its enable bit in `irq_en` is 1. The enable bits are: bit 4 for update, bit 5 for alarm, bit 6 for periodic. All other `irq_en` bits have no effect.
- R5: In `flag_byte`, bit 4 is the update flag, bit 5 the alarm flag and bit 6 the periodic flag. Bit 7 is the OR of bits 6:4. Bits 3:0 read 0.
- R6: `irq_out` equals `flag_byte[7]` and stays high on every cycle until a read clears the flags.
- R7: A `flag_rd` pulse clears all flags at that clock edge. `flag_byte` before the edge is the value read.
- R8: If an enabled event arrives in the same cycle as `flag_rd`, its flag is set after the clear.
- R9: The accumulator advances and fires whether or not periodic flags are enabled.
- R10: At most one periodic event occurs per tick. If the remainder left after subtracting P is still >= P, it is clamped to P-1.
- R11: After reset, all flags and the accumulator are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | Elapsed-time strobe |
| us_step | input | STEP_W (8) | Microseconds elapsed with this strobe |
| rate_sel | input | 4 | Periodic rate code, 0 = off |
| irq_en | input | 8 | Source enables: bit 4 update, bit 5 alarm, bit 6 periodic |
| upd_pulse | input | 1 | Update-ended event from the time counter |
| alm_pulse | input | 1 | Alarm-match event from the time counter |
| flag_rd | input | 1 | Status read strobe; clears the flags |
| flag_byte | output | 8 | Status byte: summary and source flags |
| irq_out | output | 1 | Level interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a period boundary that lands between two ticks with a leftover, for every rate code. The bench sweeps all fifteen nonzero codes with a step size that does not divide the period, and it follows the accumulator arithmetically so that it knows on which tick each event must land. The second is the clamp: the bench builds up a large residue under a slow rate and then switches to the fastest rate. It also lines up an event with a read in the same cycle, which checks that a flag set in that cycle is not lost to the clear.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned BASE_HZ    = 65536;
  localparam int unsigned US_PER_SEC = 1000000;

  // status byte bit positions (software decodes these)
  localparam int unsigned UPD_BIT = 4;
  localparam int unsigned ALM_BIT = 5;
  localparam int unsigned PER_BIT = 6;
  localparam int unsigned SUM_BIT = 7;

  localparam int unsigned NUM_SRC = 3;

  // period in microseconds for a rate code; 0 means disabled
  function automatic int unsigned period_of(input int unsigned code);
    int unsigned freq;
    if (code == 0 || code >= 32) return 0;
    freq = BASE_HZ >> code;
    if (freq == 0) return 0;
    return US_PER_SEC / freq;
  endfunction
endpackage

// File: rtl/rtc_rate_period.sv
module rtc_rate_period #(
  parameter int RATE_W = 4,
  parameter int ACC_W  = 20
) (
  input  logic [RATE_W-1:0] code,
  output logic [ACC_W-1:0]  period,
  output logic              active
);
  localparam int N_CODES = 1 << RATE_W;

  logic [ACC_W-1:0] lut [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_lut
    assign lut[g] = ACC_W'(rtc_irq_pkg::period_of(g));
  end

  assign period = lut[code];
  assign active = (period != '0);
endmodule

// File: rtl/rtc_period_acc.sv
module rtc_period_acc #(
  parameter int STEP_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  input  logic [ACC_W-1:0]  period,
  input  logic              active,
  output logic              hit
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] sum, rem, per_x;

  assign per_x = {1'b0, period};
  assign sum   = {1'b0, acc_q} + SUM_W'(step);
  assign rem   = sum - per_x;
  assign hit   = tick && active && (sum >= per_x);

  always_comb begin
    acc_d = acc_q;
    if (!active) begin
      acc_d = '0;
    end else if (tick) begin
      if (!hit)               acc_d = sum[ACC_W-1:0];
      else if (rem >= per_x)  acc_d = period - ACC_W'(1);
      else                    acc_d = rem[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= (flags[g] & ~clr) | (evt[g] & en[g]);
    end
  end
endmodule

// File: rtl/rtc_event_irq.sv
module rtc_event_irq #(
  parameter int STEP_W = 8,
  parameter int ACC_W  = 20,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic [STEP_W-1:0] us_step,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [7:0]        irq_en,
  input  logic              upd_pulse,
  input  logic              alm_pulse,
  input  logic              flag_rd,
  output logic [7:0]        flag_byte,
  output logic              irq_out
);
  import rtc_irq_pkg::*;

  logic [ACC_W-1:0]   period;
  logic               active;
  logic               per_hit;
  logic [NUM_SRC-1:0] src_evt, src_en, src_flags;

  rtc_rate_period #(.RATE_W(RATE_W), .ACC_W(ACC_W)) u_rate (
    .code   (rate_sel),
    .period (period),
    .active (active)
  );

  rtc_period_acc #(.STEP_W(STEP_W), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (us_tick),
    .step   (us_step),
    .period (period),
    .active (active),
    .hit    (per_hit)
  );

  // source order: [0] update, [1] alarm, [2] periodic
  assign src_evt = {per_hit, alm_pulse, upd_pulse};
  assign src_en  = {irq_en[PER_BIT], irq_en[ALM_BIT], irq_en[UPD_BIT]};

  rtc_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (src_evt),
    .en    (src_en),
    .clr   (flag_rd),
    .flags (src_flags)
  );

  always_comb begin
    flag_byte          = '0;
    flag_byte[UPD_BIT] = src_flags[0];
    flag_byte[ALM_BIT] = src_flags[1];
    flag_byte[PER_BIT] = src_flags[2];
    flag_byte[SUM_BIT] = |src_flags;
  end

  assign irq_out = flag_byte[SUM_BIT];
endmodule

// File: rtl/rtc_event_irq_chk.sv
module rtc_event_irq_chk #(
  parameter int STEP_W = 8,
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              us_tick,
  input logic [STEP_W-1:0] us_step,
  input logic [RATE_W-1:0] rate_sel,
  input logic [7:0]        irq_en,
  input logic              upd_pulse,
  input logic              alm_pulse,
  input logic              flag_rd,
  input logic [7:0]        flag_byte,
  input logic              irq_out
);
  // R6
  irq_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !flag_rd) |=> irq_out);

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !us_tick && !upd_pulse && !alm_pulse) |=> (flag_byte == 8'h00));

  // R8
  read_keeps_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && upd_pulse && irq_en[4]) |=> flag_byte[4]);

  // R4
  upd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_byte[4]) |-> $past(upd_pulse && irq_en[4]));

  // R4
  alm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_byte[5]) |-> $past(alm_pulse && irq_en[5]));

  // R3
  rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0 && !flag_byte[6]) |=> !flag_byte[6]);
endmodule

bind rtc_event_irq rtc_event_irq_chk #(.STEP_W(STEP_W), .RATE_W(RATE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .us_tick   (us_tick),
  .us_step   (us_step),
  .rate_sel  (rate_sel),
  .irq_en    (irq_en),
  .upd_pulse (upd_pulse),
  .alm_pulse (alm_pulse),
  .flag_rd   (flag_rd),
  .flag_byte (flag_byte),
  .irq_out   (irq_out)
);

// File: tb/rtc_event_irq_test.sv
`timescale 1ns/1ps
module rtc_event_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic [7:0] us_step = '0;
  logic [3:0] rate_sel = '0;
  logic [7:0] irq_en = '0;
  logic       upd_pulse = 1'b0;
  logic       alm_pulse = 1'b0;
  logic       flag_rd = 1'b0;
  logic [7:0] flag_byte;
  logic       irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  int m_acc = 0;
  logic [2:0] m_flags = '0;  // {per, alm, upd}
  logic m_fire = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_event_irq uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .us_step(us_step),
    .rate_sel(rate_sel), .irq_en(irq_en), .upd_pulse(upd_pulse),
    .alm_pulse(alm_pulse), .flag_rd(flag_rd), .flag_byte(flag_byte),
    .irq_out(irq_out)
  );

  function automatic int per_us(input int code);
    if (code == 0) return 0;
    return 1000000 / (65536 >> code);
  endfunction

  function automatic logic [7:0] exp_byte();
    return {|m_flags, m_flags, 4'b0000};
  endfunction

  task automatic check(input string tag);
    n_cmp++;
    if (flag_byte !== exp_byte() || irq_out !== |m_flags) begin
      n_bad++;
      $display("FAIL %s: flag_byte=%h irq=%b expected %h irq=%b",
               tag, flag_byte, irq_out, exp_byte(), |m_flags);
    end
  endtask

  // one clock: drive, step the model, sample after the edge
  task automatic cyc(input logic tk, input int st, input logic up,
                     input logic al, input logic rd, input string tag);
    int p;
    us_tick = tk; us_step = 8'(st); upd_pulse = up; alm_pulse = al; flag_rd = rd;
    p = per_us(int'(rate_sel));
    m_fire = 1'b0;
    if (p == 0) m_acc = 0;
    else if (tk) begin
      if (m_acc + st >= p) begin
        m_fire = 1'b1;
        m_acc = m_acc + st - p;
        if (m_acc >= p) m_acc = p - 1;
      end else m_acc = m_acc + st;
    end
    if (rd) m_flags = '0;
    m_flags |= {m_fire & irq_en[6], al & irq_en[5], up & irq_en[4]};
    @(posedge clk); #1;
    us_tick = 0; us_step = '0; upd_pulse = 0; alm_pulse = 0; flag_rd = 0;
    check(tag);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R11 after reset");

    // R5 / R6 / R7: single sources, positions, level, clear
    irq_en = 8'h70;
    cyc(0, 0, 1, 0, 0, "R5 update bit");
    cyc(0, 0, 0, 0, 0, "R6 irq held");
    cyc(0, 0, 0, 0, 0, "R6 irq held");
    cyc(0, 0, 0, 0, 1, "R7 read clears");
    cyc(0, 0, 0, 1, 0, "R5 alarm bit");
    cyc(0, 0, 1, 0, 0, "R5 both bits");
    cyc(0, 0, 0, 0, 1, "R7 read clears");

    // R8: event during read survives
    cyc(0, 0, 0, 1, 0, "R8 setup");
    cyc(0, 0, 1, 0, 1, "R8 event with read");
    cyc(0, 0, 0, 0, 1, "R7 read clears");

    // R4: enables off, and unrelated enable bits ignored
    irq_en = 8'h8F;
    cyc(0, 0, 1, 1, 0, "R4 disabled sources");
    rate_sel = 4'd1;
    for (int k = 0; k < 40; k++) cyc(1, 1, 0, 0, 0, "R4 periodic disabled");
    irq_en = 8'h20;
    cyc(0, 0, 1, 0, 0, "R4 update masked");
    cyc(0, 0, 0, 1, 0, "R4 alarm enabled");
    cyc(0, 0, 0, 0, 1, "R7 read clears");

    // R9: accumulator kept running while periodic flags were off
    irq_en = 8'h40;
    for (int k = 0; k < 35; k++) begin
      cyc(1, 1, 0, 0, 0, "R9 running phase");
      if (m_fire) cyc(0, 0, 0, 0, 1, "R7 read clears");
    end

    // R1 / R2: sweep every rate code
    for (int r = 1; r < 16; r++) begin
      int p, st, fires;
      rate_sel = 4'd0;
      cyc(1, 200, 0, 0, 0, "R3 clear between rates");
      rate_sel = 4'(r);
      p = per_us(r);
      st = p / 50 + 1;
      if (r <= 2) st = 7;
      if (st > 255) st = 255;
      fires = 0;
      while (fires < 3) begin
        cyc(1, st, 0, 0, 0, "R1 R2 period sweep");
        if (m_fire) begin
          fires++;
          cyc(0, 0, 0, 0, 1, "R7 read clears");
        end
      end
    end

    // R3: code 0 never fires and clears the residue
    rate_sel = 4'd1;
    cyc(1, 20, 0, 0, 0, "R3 build residue");
    rate_sel = 4'd0;
    for (int k = 0; k < 10; k++) cyc(1, 255, 0, 0, 0, "R3 rate off");
    rate_sel = 4'd1;
    cyc(1, 29, 0, 0, 0, "R3 residue cleared");
    cyc(1, 1, 0, 0, 0, "R3 fires at period");
    cyc(0, 0, 0, 0, 1, "R7 read clears");

    // R10: large residue, then fastest rate
    rate_sel = 4'd0;
    cyc(0, 0, 0, 0, 0, "R10 clear");
    rate_sel = 4'd15;
    for (int k = 0; k < 10; k++) cyc(1, 255, 0, 0, 0, "R10 build residue");
    rate_sel = 4'd1;
    cyc(1, 1, 0, 0, 0, "R10 first fire");
    cyc(0, 0, 0, 0, 1, "R7 read clears");
    cyc(1, 1, 0, 0, 0, "R10 clamped residue fires");
    cyc(0, 0, 0, 0, 1, "R7 read clears");
    cyc(1, 1, 0, 0, 0, "R10 no third fire");
    for (int k = 0; k < 3; k++) cyc(1, 1, 0, 0, 0, "R10 settle");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule